// File: doc/BRIEF.md
# Bus-Sliced Dual-Port Memory

This block is a two-port on-chip memory. A host register bus with a 16-bit data path reaches it through the first port, and user logic reaches it through the second. The user port is a plain synchronous memory port. It has an entry address, a full-width write word, a write strobe and a registered read word, so user logic reads and writes whole entries in one cycle.

The host never sees a whole entry at once. Each entry is cut into 16-bit pieces, and every piece has its own host address. A host transaction therefore reads or writes exactly one piece. Updating a wide entry from the host takes one transaction per piece, and between those transactions the user port may see an entry that holds part old data and part new data. The block does not hide this. Any scheme that makes wide updates appear atomic belongs to the surrounding logic.

The entry width and the depth are parameters. The storage is built as one memory bank per piece, so a host write to one piece cannot disturb the others.

Top module: `sliced_dpram`

## Requirements
- R1: An entry of ENTRY_W bits spans NSLICE = ceil(ENTRY_W/16) pieces. Piece s holds entry bits [16s+15:16s]. The host address of piece s of entry e is e*NSLICE + s.
- R2: A host write to one piece of an entry leaves every other piece of that entry unchanged.
- R3: A host read returns the addressed piece on hst_rdata one clock after the address is presented. A partial last piece is zero-extended to 16 bits, and a host write to it stores only its low ENTRY_W-16*(NSLICE-1) bits.
- R4: A host address of DEPTH*NSLICE or more is out of range. A write to it changes no entry, and a read of it returns zero.
- R5: The user port writes a whole entry when usr_we is high, and it returns the entry at usr_addr on usr_rdata one clock after the address.
- R6: On both ports, a read in the same cycle as a write to the same location returns the data held before the write.
- R7: When the host and the user port write the same entry in the same cycle, the user data is stored for every piece, including the piece the host addressed.
- R8: After a host writes some pieces of an entry, a user read of that entry returns the new pieces together with the old contents of the pieces not yet written.
- R9: While rst is high, both hst_rdata and usr_rdata are zero.
- R10: When ENTRY_W is 16 or less, each entry has exactly one host address, equal to its entry index, and one host transaction reads or writes the whole entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| hst_addr | input | HAW = clog2(DEPTH*NSLICE) | Host piece address |
| hst_we | input | 1 | Host write strobe |
| hst_wdata | input | 16 | Host write piece |
| hst_rdata | output | 16 | Host read piece, one cycle latency |
| usr_addr | input | UAW = clog2(DEPTH) | User entry address |
| usr_we | input | 1 | User write strobe |
| usr_wdata | input | ENTRY_W | User write entry |
| usr_rdata | output | ENTRY_W | User read entry, one cycle latency |

## Verification
The assertions check the following on every cycle: out-of-range host reads return zero, the upper bits of a partial last piece stay clear, a host piece or user entry that was just written reads back unchanged, and the user port wins a same-cycle write to a shared entry. Some behaviours can only be shown by the bench's scenarios, because they depend on a history of several writes. These are that neighbouring pieces survive a host write, that a half-updated entry is visible from the user side, that both ports return old data on a read during a write, and that a narrow instance maps one host address to one whole entry.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    localparam int HOST_W = 16;

    // number of host-sized pieces covering an entry
    function automatic int piece_count(input int entry_w);
        return (entry_w + HOST_W - 1) / HOST_W;
    endfunction

    // width of piece s of an entry (last one may be partial)
    function automatic int piece_width(input int entry_w, input int s);
        int rem;
        rem = entry_w - s * HOST_W;
        return (rem > HOST_W) ? HOST_W : rem;
    endfunction

    // address width that never collapses to zero
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bsm_host_decode.sv
module bsm_host_decode #(
    parameter int ENTRY_W = 40,
    parameter int DEPTH   = 256,
    localparam int NSLICE = bsm_pkg::piece_count(ENTRY_W),
    localparam int TOTAL  = DEPTH * NSLICE,
    localparam int HAW    = bsm_pkg::idx_width(TOTAL),
    localparam int UAW    = bsm_pkg::idx_width(DEPTH),
    localparam int SLW    = bsm_pkg::idx_width(NSLICE)
) (
    input  logic [HAW-1:0] hst_addr,
    output logic           hit,
    output logic [UAW-1:0] entry,
    output logic [SLW-1:0] piece
);
    always_comb begin
        hit   = 32'(hst_addr) < 32'(TOTAL);
        entry = UAW'(32'(hst_addr) / 32'(NSLICE));
        piece = SLW'(32'(hst_addr) % 32'(NSLICE));
    end
endmodule

// File: rtl/bsm_piece_bank.sv
module bsm_piece_bank #(
    parameter int PW    = 16,
    parameter int DEPTH = 256,
    localparam int UAW  = bsm_pkg::idx_width(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           h_we,
    input  logic [UAW-1:0] h_addr,
    input  logic [PW-1:0]  h_wdata,
    output logic [PW-1:0]  h_q,
    input  logic           u_we,
    input  logic [UAW-1:0] u_addr,
    input  logic [PW-1:0]  u_wdata,
    output logic [PW-1:0]  u_q
);
    logic [PW-1:0] mem [DEPTH];

    // user write issued last so it wins a same-entry collision
    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        if (u_we) mem[u_addr] <= u_wdata;
    end

    // read-first registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            u_q <= '0;
        end else begin
            h_q <= mem[h_addr];
            u_q <= mem[u_addr];
        end
    end
endmodule

// File: rtl/bsm_port_out.sv
module bsm_port_out #(
    parameter int ENTRY_W = 40,
    localparam int NSLICE = bsm_pkg::piece_count(ENTRY_W),
    localparam int SLW    = bsm_pkg::idx_width(NSLICE),
    localparam int PADW   = NSLICE * bsm_pkg::HOST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_hit,
    input  logic [SLW-1:0]     h_piece,
    input  logic [ENTRY_W-1:0] h_word,
    input  logic               u_hit,
    input  logic [ENTRY_W-1:0] u_word,
    output logic [15:0]        hst_rdata,
    output logic [ENTRY_W-1:0] usr_rdata
);
    logic           h_hit_q, u_hit_q;
    logic [SLW-1:0] h_piece_q;
    logic [PADW-1:0] h_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_hit_q   <= 1'b0;
            u_hit_q   <= 1'b0;
            h_piece_q <= '0;
        end else begin
            h_hit_q   <= h_hit;
            u_hit_q   <= u_hit;
            h_piece_q <= h_piece;
        end
    end

    always_comb begin
        h_pad = '0;
        h_pad[ENTRY_W-1:0] = h_word;
        hst_rdata = h_hit_q ? h_pad[int'(h_piece_q) * bsm_pkg::HOST_W +: 16] : 16'h0;
        usr_rdata = u_hit_q ? u_word : '0;
    end
endmodule

// File: rtl/sliced_dpram.sv
module sliced_dpram #(
    parameter int ENTRY_W = 40,
    parameter int DEPTH   = 256,
    localparam int NSLICE = bsm_pkg::piece_count(ENTRY_W),
    localparam int TOTAL  = DEPTH * NSLICE,
    localparam int HAW    = bsm_pkg::idx_width(TOTAL),
    localparam int UAW    = bsm_pkg::idx_width(DEPTH),
    localparam int SLW    = bsm_pkg::idx_width(NSLICE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HAW-1:0]     hst_addr,
    input  logic               hst_we,
    input  logic [15:0]        hst_wdata,
    output logic [15:0]        hst_rdata,
    input  logic [UAW-1:0]     usr_addr,
    input  logic               usr_we,
    input  logic [ENTRY_W-1:0] usr_wdata,
    output logic [ENTRY_W-1:0] usr_rdata
);
    typedef struct packed {
        logic           hit;
        logic [UAW-1:0] entry;
        logic [SLW-1:0] piece;
    } host_sel_t;

    host_sel_t          hsel;
    logic               u_hit;
    logic [ENTRY_W-1:0] h_word, u_word;

    bsm_host_decode #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) dec_i (
        .hst_addr (hst_addr),
        .hit      (hsel.hit),
        .entry    (hsel.entry),
        .piece    (hsel.piece)
    );

    always_comb u_hit = 32'(usr_addr) < 32'(DEPTH);

    for (genvar s = 0; s < NSLICE; s++) begin : g_piece
        localparam int PW = bsm_pkg::piece_width(ENTRY_W, s);
        localparam int LO = s * bsm_pkg::HOST_W;
        logic h_we_s;
        always_comb h_we_s = hst_we && hsel.hit && (int'(hsel.piece) == s);

        bsm_piece_bank #(.PW(PW), .DEPTH(DEPTH)) bank_i (
            .clk     (clk),
            .rst     (rst),
            .h_we    (h_we_s),
            .h_addr  (hsel.entry),
            .h_wdata (hst_wdata[PW-1:0]),
            .h_q     (h_word[LO +: PW]),
            .u_we    (usr_we && u_hit),
            .u_addr  (usr_addr),
            .u_wdata (usr_wdata[LO +: PW]),
            .u_q     (u_word[LO +: PW])
        );
    end

    bsm_port_out #(.ENTRY_W(ENTRY_W)) out_i (
        .clk       (clk),
        .rst       (rst),
        .h_hit     (hsel.hit),
        .h_piece   (hsel.piece),
        .h_word    (h_word),
        .u_hit     (u_hit),
        .u_word    (u_word),
        .hst_rdata (hst_rdata),
        .usr_rdata (usr_rdata)
    );
endmodule

// File: rtl/sliced_dpram_checker.sv
module sliced_dpram_checker #(
    parameter int ENTRY_W = 40,
    parameter int DEPTH   = 256,
    localparam int NSLICE = bsm_pkg::piece_count(ENTRY_W),
    localparam int TOTAL  = DEPTH * NSLICE,
    localparam int HAW    = bsm_pkg::idx_width(TOTAL),
    localparam int UAW    = bsm_pkg::idx_width(DEPTH),
    localparam int LASTW  = bsm_pkg::piece_width(ENTRY_W, NSLICE - 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [HAW-1:0]     hst_addr,
    input logic               hst_we,
    input logic [15:0]        hst_wdata,
    input logic [15:0]        hst_rdata,
    input logic [UAW-1:0]     usr_addr,
    input logic               usr_we,
    input logic [ENTRY_W-1:0] usr_wdata,
    input logic [ENTRY_W-1:0] usr_rdata
);
    logic h_in, h_last, u_in, same_entry;

    always_comb begin
        h_in       = 32'(hst_addr) < 32'(TOTAL);
        h_last     = (32'(hst_addr) % 32'(NSLICE)) == 32'(NSLICE - 1);
        u_in       = 32'(usr_addr) < 32'(DEPTH);
        same_entry = (32'(hst_addr) / 32'(NSLICE)) == 32'(usr_addr);
    end

    AST_RANGE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !h_in |=> (hst_rdata == 16'h0)); // R4

    AST_SLICE_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
        (hst_we && h_in && !h_last && !usr_we) ##1 (!hst_we && !usr_we && $stable(hst_addr))
        |=> (hst_rdata == $past(hst_wdata, 2))); // R1

    AST_USER_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
        (usr_we && u_in && !hst_we) ##1 (!usr_we && !hst_we && $stable(usr_addr))
        |=> (usr_rdata == $past(usr_wdata, 2))); // R5

    AST_USER_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (usr_we && u_in && hst_we && h_in && same_entry) ##1 (!usr_we && !hst_we && $stable(usr_addr))
        |=> (usr_rdata == $past(usr_wdata, 2))); // R7

    if (LASTW < 16) begin : g_zext
        AST_PARTIAL_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
            (h_in && h_last) |=> (hst_rdata[15:LASTW] == '0)); // R3
    end
endmodule

bind sliced_dpram sliced_dpram_checker #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .hst_addr  (hst_addr),
    .hst_we    (hst_we),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .usr_addr  (usr_addr),
    .usr_we    (usr_we),
    .usr_wdata (usr_wdata),
    .usr_rdata (usr_rdata)
);

// File: tb/sliced_dpram_tb_top.sv
module sliced_dpram_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk; // 250 MHz

    // main instance: 40-bit entries, 3 pieces, last piece 8 bits
    logic [9:0]  hst_addr = '0;
    logic        hst_we = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic [7:0]  usr_addr = '0;
    logic        usr_we = 1'b0;
    logic [39:0] usr_wdata = '0;
    logic [39:0] usr_rdata;

    sliced_dpram #(.ENTRY_W(40), .DEPTH(256)) dut_i (
        .clk(clk), .rst(rst),
        .hst_addr(hst_addr), .hst_we(hst_we), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .usr_addr(usr_addr), .usr_we(usr_we), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata)
    );

    // narrow instance: 12-bit entries, one piece each
    logic [3:0]  n_hst_addr = '0;
    logic        n_hst_we = 1'b0;
    logic [15:0] n_hst_wdata = '0;
    logic [15:0] n_hst_rdata;
    logic [3:0]  n_usr_addr = '0;
    logic [11:0] n_usr_rdata;

    sliced_dpram #(.ENTRY_W(12), .DEPTH(16)) narrow_i (
        .clk(clk), .rst(rst),
        .hst_addr(n_hst_addr), .hst_we(n_hst_we), .hst_wdata(n_hst_wdata), .hst_rdata(n_hst_rdata),
        .usr_addr(n_usr_addr), .usr_we(1'b0), .usr_wdata(12'h0), .usr_rdata(n_usr_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [9:0] a, input logic [15:0] d, output logic [15:0] old);
        @(negedge clk); hst_addr = a; hst_wdata = d; hst_we = 1'b1;
        @(negedge clk); old = hst_rdata; hst_we = 1'b0;
    endtask

    task automatic host_read(input logic [9:0] a, output logic [15:0] v);
        @(negedge clk); hst_addr = a; hst_we = 1'b0;
        @(negedge clk); v = hst_rdata;
    endtask

    task automatic user_write(input logic [7:0] a, input logic [39:0] d, output logic [39:0] old);
        @(negedge clk); usr_addr = a; usr_wdata = d; usr_we = 1'b1;
        @(negedge clk); old = usr_rdata; usr_we = 1'b0;
    endtask

    task automatic user_read(input logic [7:0] a, output logic [39:0] v);
        @(negedge clk); usr_addr = a; usr_we = 1'b0;
        @(negedge clk); v = usr_rdata;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R9 host rdata in reset", 64'(hst_rdata), 64'h0);
        chk("R9 user rdata in reset", 64'(usr_rdata), 64'h0);
        rst = 1'b0;
    endtask

    task automatic t_piece_map();
        logic [15:0] h; logic [39:0] u;
        user_write(8'd5, 40'hAB_CDEF_1234, u);
        host_read(10'd15, h); chk("R1 entry5 piece0", 64'(h), 64'h1234);
        host_read(10'd16, h); chk("R1 entry5 piece1", 64'(h), 64'hCDEF);
        host_read(10'd17, h); chk("R3 entry5 partial piece zero-extended", 64'(h), 64'h00AB);
        user_read(8'd5, u);   chk("R5 user full entry", 64'(u), 64'hAB_CDEF_1234);
    endtask

    task automatic t_piece_write();
        logic [15:0] h; logic [39:0] u;
        host_write(10'd16, 16'hBEEF, h); chk("R6 host read-first", 64'(h), 64'hCDEF);
        host_read(10'd15, h); chk("R2 piece0 preserved", 64'(h), 64'h1234);
        host_read(10'd17, h); chk("R2 piece2 preserved", 64'(h), 64'h00AB);
        user_read(8'd5, u);   chk("R8 mixed old and new pieces", 64'(u), 64'hAB_BEEF_1234);
    endtask

    task automatic t_range();
        logic [15:0] h; logic [39:0] u;
        user_write(8'd10, 40'h55_6666_7777, u);
        host_write(10'd798, 16'h9999, h); chk("R4 out-of-range read during write", 64'(h), 64'h0);
        host_read(10'd798, h); chk("R4 out-of-range read", 64'(h), 64'h0);
        user_read(8'd10, u);   chk("R4 aliased entry untouched", 64'(u), 64'h55_6666_7777);
    endtask

    task automatic t_user_read_first();
        logic [15:0] h; logic [39:0] u;
        user_write(8'd5, 40'h01_0203_0405, u); chk("R6 user read-first", 64'(u), 64'hAB_BEEF_1234);
        host_read(10'd15, h); chk("R5 user write seen by host", 64'(h), 64'h0405);
    endtask

    task automatic t_collision();
        logic [15:0] h; logic [39:0] u;
        user_write(8'd7, 40'hFF_FFFF_FFFF, u);
        @(negedge clk);
        hst_addr = 10'd22; hst_wdata = 16'h5555; hst_we = 1'b1;
        usr_addr = 8'd7; usr_wdata = 40'h11_2222_3333; usr_we = 1'b1;
        @(negedge clk); hst_we = 1'b0; usr_we = 1'b0;
        host_read(10'd22, h); chk("R7 user wins on host piece", 64'(h), 64'h2222);
        host_read(10'd21, h); chk("R7 other piece from user", 64'(h), 64'h3333);
        user_read(8'd7, u);   chk("R7 user entry intact", 64'(u), 64'h11_2222_3333);
    endtask

    task automatic t_partial_write();
        logic [15:0] h;
        host_write(10'd17, 16'hFFC3, h);
        host_read(10'd17, h); chk("R3 partial piece truncated on write", 64'(h), 64'h00C3);
    endtask

    task automatic t_narrow();
        @(negedge clk); n_hst_addr = 4'd3; n_hst_wdata = 16'hFABC; n_hst_we = 1'b1;
        @(negedge clk); n_hst_we = 1'b0;
        @(negedge clk); n_usr_addr = 4'd3;
        chk("R10 narrow host read whole entry", 64'(n_hst_rdata), 64'h0ABC);
        @(negedge clk);
        chk("R10 narrow user sees entry", 64'(n_usr_rdata), 64'hABC);
    endtask

    initial begin
        t_reset();
        t_piece_map();
        t_piece_write();
        t_range();
        t_user_read_first();
        t_collision();
        t_partial_write();
        t_narrow();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule